// File: doc/BRIEF.md
# Encoder bitstream buffer interrupt tracker

This block follows the write position of a video encoder inside a circular bitstream buffer in memory. The encoder pulses an advance strobe with the number of bytes it has just stored. The block moves its current pointer by that amount and wraps it from the buffer end back to the buffer start. The encoder also pulses a frame-done strobe whenever it completes a frame. For each one the block records the pointer value as the frame-end address. It keeps up to two unread frame-end reports.

Software reaches the block through a small register port with read and write strobes. Through it, software sets the buffer start, the buffer end and an alert threshold. It can read the current pointer. It reads a status register and clears its bits by writing 1 to them. It collects frame-end reports from a register that clears on read. All status bits are combined into one interrupt output.

Register map, 3-bit word index: 0 buffer start (R/W), 1 buffer end (R/W), 2 alert threshold (R/W), 3 current pointer (read-only), 4 status (read, write-1-to-clear), 5 frame-end report (read-clears). Indices 6 and 7 read as zero. Addresses are 24 bits wide and the data port is 32 bits wide.

Top module: `enc_bitbuf_irq`

## Requirements
- R1: After reset, the status register, the frame-end report, the current pointer and irq_o are all zero. The buffer end and the alert threshold reset to 0xFFFFFF.
- R2: An advance strobe with a byte count of n moves the current pointer forward by n in the same clock edge, as long as pointer + n stays below the buffer end.
- R3: When pointer + n is equal to or greater than the buffer end, the pointer becomes buffer start + (pointer + n − buffer end), and status bit 2 is set at that same edge.
- R4: Status bit 0 is set on the edge after the pointer is equal to or greater than the alert threshold. After it is cleared, it is set again one cycle later while that condition still holds. Once the threshold is moved above the pointer, it stays clear.
- R5: Writing to the status register clears every bit (0 to 3) whose write-data bit is 1. Bits 4 to 7 and above always read as zero.
- R6: A frame-done strobe sets status bit 1 at the same edge. While an unread frame-end report is pending, bit 1 is set again one cycle after each clear.
- R7: A frame-end report reads as {code[31:24], address[23:0]}. The code is 0x09 in the normal case, and the address is the current pointer at the time of the strobe. A read returns the oldest pending report and removes it, and with no report pending the register reads zero.
- R8: Two unread reports are held. Successive reads return the older one, then the newer one, then zero.
- R9: A frame-done strobe that arrives while two reports are unread sets status bit 3. It replaces the backlog with a single report that carries code 0x0E and the newest address.
- R10: irq_o is high exactly when at least one status bit is set.
- R11: A write to the buffer start also loads that value into the current pointer. Writes to the current-pointer index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_valid_i | input | 1 | Encoder stored adv_bytes_i bytes this cycle |
| adv_bytes_i | input | 16 | Byte count of the advance |
| frame_done_i | input | 1 | Encoder completed a frame this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is the overflow of the frame-end backlog. It needs three frame completions with no report read in between, and each at a different pointer value, so that the stored address shows which report survived. The stimulus interleaves frame-done pulses with small advances and reads the report register only after the third pulse. The re-assertion of the alert and frame bits is visible only in the single cycle right after a clear. For that reason, the bench reads status immediately after the clear write and again one cycle later.

// File: rtl/enc_bb_pkg.sv
package enc_bb_pkg;

  typedef enum logic [2:0] {
    REG_START = 3'd0,
    REG_END   = 3'd1,
    REG_ALERT = 3'd2,
    REG_CUR   = 3'd3,
    REG_STAT  = 3'd4,
    REG_FRAME = 3'd5
  } reg_sel_e;

  localparam int          NUM_IRQ  = 4;
  localparam int          IRQ_ALRT = 0;
  localparam int          IRQ_FRM  = 1;
  localparam int          IRQ_WRAP = 2;
  localparam int          IRQ_OVF  = 3;

  localparam int          CODE_W   = 8;
  localparam logic [7:0]  CODE_OK  = 8'h09;
  localparam logic [7:0]  CODE_OVF = 8'h0E;

endpackage

// File: rtl/enc_bb_ptr.sv
module enc_bb_ptr #(
  parameter int PTR_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] start_i,
  input  logic [PTR_W-1:0] end_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] bytes_i,
  output logic [PTR_W-1:0] cur_o,
  output logic             wrap_o
);

  localparam int SUM_W = PTR_W + 1;

  logic [PTR_W-1:0] cur_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] excess;
  logic [PTR_W-1:0] cur_d;

  always_comb begin
    sum    = {1'b0, cur_q} + SUM_W'(bytes_i);
    excess = sum - {1'b0, end_i};
    wrap_o = adv_i && !load_i && (sum >= {1'b0, end_i});
    cur_d  = cur_q;
    if (load_i)      cur_d = load_val_i;
    else if (wrap_o) cur_d = start_i + excess[PTR_W-1:0];
    else if (adv_i)  cur_d = sum[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/enc_bb_fq.sv
module enc_bb_fq #(
  parameter int PTR_W  = 24,
  parameter int CODE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [PTR_W-1:0]        addr_i,
  input  logic                    pop_i,
  output logic [PTR_W+CODE_W-1:0] head_o,
  output logic                    pend_o,
  output logic                    ovf_o,
  output logic [1:0]              cnt_o
);

  import enc_bb_pkg::*;

  localparam int ENT_W = PTR_W + CODE_W;

  logic [ENT_W-1:0] e0_q, e1_q;
  logic [1:0]       cnt_q;
  logic             pop_eff;
  logic [ENT_W-1:0] new_ent;

  assign pop_eff = pop_i && (cnt_q != 2'd0);
  assign ovf_o   = push_i && !pop_eff && (cnt_q == 2'd2);
  assign new_ent = {CODE_W'(CODE_OK), addr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e0_q  <= '0;
      e1_q  <= '0;
      cnt_q <= 2'd0;
    end else if (ovf_o) begin
      // backlog lost: keep only the newest address, flagged
      e0_q  <= {CODE_W'(CODE_OVF), addr_i};
      cnt_q <= 2'd1;
    end else begin
      unique case ({push_i, pop_eff})
        2'b10: begin
          if (cnt_q == 2'd0) e0_q <= new_ent;
          else               e1_q <= new_ent;
          cnt_q <= cnt_q + 2'd1;
        end
        2'b01: begin
          e0_q  <= e1_q;
          cnt_q <= cnt_q - 2'd1;
        end
        2'b11: begin
          if (cnt_q == 2'd1) e0_q <= new_ent;
          else begin
            e0_q <= e1_q;
            e1_q <= new_ent;
          end
        end
        default: ;
      endcase
    end
  end

  assign pend_o = (cnt_q != 2'd0);
  assign head_o = pend_o ? e0_q : '0;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/enc_bb_stat.sv
module enc_bb_stat #(
  parameter int N_IRQ  = 4,
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  set_i,
  input  logic [N_IRQ-1:0]  cond_i,
  input  logic [N_IRQ-1:0]  clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);

  logic [N_IRQ-1:0] st_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    // events always land; a standing condition waits one cycle after a clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= 1'b0;
      else         st_q[i] <= set_i[i] | ((st_q[i] | cond_i[i]) & ~clr_i[i]);
    end
  end

  assign stat_o = STAT_W'(st_q);
  assign irq_o  = |st_q;

endmodule

// File: rtl/enc_bitbuf_irq.sv
module enc_bitbuf_irq #(
  parameter int PTR_W  = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_valid_i,
  input  logic [CNT_W-1:0]  adv_bytes_i,
  input  logic              frame_done_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  import enc_bb_pkg::*;

  localparam int ENT_W = PTR_W + CODE_W;

  logic [PTR_W-1:0]   start_q, end_q, alert_q;
  logic [PTR_W-1:0]   cur;
  logic               wrap;
  logic               wr_start, wr_end, wr_alert, wr_stat, rd_frame;
  logic [PTR_W-1:0]   wval;
  logic [ENT_W-1:0]   fq_head;
  logic               fq_pend, fq_ovf;
  logic [1:0]         fq_cnt;
  logic               alert_hit;
  logic [NUM_IRQ-1:0] st_set, st_cond, st_clr;
  logic [STAT_W-1:0]  stat;
  logic               unused_wdata;

  assign wval         = reg_wdata_i[PTR_W-1:0];
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:PTR_W];

  assign wr_start = reg_wr_i && (reg_addr_i == REG_START);
  assign wr_end   = reg_wr_i && (reg_addr_i == REG_END);
  assign wr_alert = reg_wr_i && (reg_addr_i == REG_ALERT);
  assign wr_stat  = reg_wr_i && (reg_addr_i == REG_STAT);
  assign rd_frame = reg_rd_i && (reg_addr_i == REG_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '1;
      alert_q <= '1;
    end else begin
      if (wr_start) start_q <= wval;
      if (wr_end)   end_q   <= wval;
      if (wr_alert) alert_q <= wval;
    end
  end

  enc_bb_ptr #(
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_q),
    .end_i      (end_q),
    .load_i     (wr_start),
    .load_val_i (wval),
    .adv_i      (adv_valid_i),
    .bytes_i    (adv_bytes_i),
    .cur_o      (cur),
    .wrap_o     (wrap)
  );

  enc_bb_fq #(
    .PTR_W  (PTR_W),
    .CODE_W (CODE_W)
  ) i_fq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (frame_done_i),
    .addr_i (cur),
    .pop_i  (rd_frame),
    .head_o (fq_head),
    .pend_o (fq_pend),
    .ovf_o  (fq_ovf),
    .cnt_o  (fq_cnt)
  );

  assign alert_hit = (cur >= alert_q);

  always_comb begin
    st_set  = '0;
    st_cond = '0;
    st_set[IRQ_FRM]   = frame_done_i;
    st_set[IRQ_WRAP]  = wrap;
    st_set[IRQ_OVF]   = fq_ovf;
    st_cond[IRQ_ALRT] = alert_hit;
    st_cond[IRQ_FRM]  = fq_pend;
    st_clr = wr_stat ? reg_wdata_i[NUM_IRQ-1:0] : '0;
  end

  enc_bb_stat #(
    .N_IRQ  (NUM_IRQ),
    .STAT_W (STAT_W)
  ) i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (st_set),
    .cond_i (st_cond),
    .clr_i  (st_clr),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_START: reg_rdata_o = DATA_W'(start_q);
      REG_END:   reg_rdata_o = DATA_W'(end_q);
      REG_ALERT: reg_rdata_o = DATA_W'(alert_q);
      REG_CUR:   reg_rdata_o = DATA_W'(cur);
      REG_STAT:  reg_rdata_o = DATA_W'(stat);
      REG_FRAME: reg_rdata_o = DATA_W'(fq_head);
      default:   reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/enc_bb_chk.sv
module enc_bb_chk #(
  parameter int PTR_W  = 24,
  parameter int CNT_W  = 16,
  parameter int N_IRQ  = 4,
  parameter int STAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_valid_i,
  input logic [CNT_W-1:0]  adv_bytes_i,
  input logic              load,
  input logic              wrap,
  input logic              ovf,
  input logic              pend,
  input logic [1:0]        cnt,
  input logic              alert_hit,
  input logic [N_IRQ-1:0]  clr,
  input logic [PTR_W-1:0]  cur,
  input logic [STAT_W-1:0] stat,
  input logic              irq_o
);

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_valid_i && !wrap && !load) |=> cur == $past(cur) + PTR_W'($past(adv_bytes_i)));

  a_r3_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> stat[2]);

  a_r4_alert_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_hit && !clr[0]) |=> stat[0]);

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr[0] |=> !stat[0]);

  a_r6_pending_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !clr[1]) |=> irq_o);

  a_r8_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != 2'd3);

  a_r9_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (stat[3] && cnt == 2'd1));

endmodule

bind enc_bitbuf_irq enc_bb_chk #(
  .PTR_W  (PTR_W),
  .CNT_W  (CNT_W),
  .N_IRQ  (enc_bb_pkg::NUM_IRQ),
  .STAT_W (STAT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adv_valid_i (adv_valid_i),
  .adv_bytes_i (adv_bytes_i),
  .load        (wr_start),
  .wrap        (wrap),
  .ovf         (fq_ovf),
  .pend        (fq_pend),
  .cnt         (fq_cnt),
  .alert_hit   (alert_hit),
  .clr         (st_clr),
  .cur         (cur),
  .stat        (stat),
  .irq_o       (irq_o)
);

// File: tb/test_enc_bitbuf_irq.sv
module test_enc_bitbuf_irq;

  localparam logic [2:0] A_START = 3'd0, A_END = 3'd1, A_ALERT = 3'd2,
                         A_CUR = 3'd3, A_STAT = 3'd4, A_FRAME = 3'd5;

  typedef struct packed {
    logic [15:0] bytes;
    logic [23:0] cur;
    logic        wrap;
  } vec_t;

  // buffer [0x100, 0x200), start at 0x100
  localparam vec_t VEC [6] = '{
    '{16'h0040, 24'h000140, 1'b0},
    '{16'h0080, 24'h0001C0, 1'b0},
    '{16'h0040, 24'h000100, 1'b1},
    '{16'h0030, 24'h000130, 1'b0},
    '{16'h00E0, 24'h000110, 1'b1},
    '{16'h0000, 24'h000110, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv;
  logic [15:0] bytes;
  logic        fdone;
  logic        wr, rd;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  enc_bitbuf_irq i_enc_bitbuf_irq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .adv_valid_i  (adv),
    .adv_bytes_i  (bytes),
    .frame_done_i (fdone),
    .reg_wr_i     (wr),
    .reg_rd_i     (rd),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .irq_o        (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic advance(input logic [15:0] b);
    adv = 1'b1; bytes = b;
    @(posedge clk); #1;
    adv = 1'b0; bytes = '0;
  endtask

  task automatic frame_pulse();
    fdone = 1'b1;
    @(posedge clk); #1;
    fdone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; adv = 1'b0; bytes = '0; fdone = 1'b0;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    reg_rd(A_STAT, d);  check("R1 status", d, 32'h0);
    reg_rd(A_CUR, d);   check("R1 pointer", d, 32'h0);
    reg_rd(A_FRAME, d); check("R1 frame report", d, 32'h0);
    reg_rd(A_END, d);   check("R1 end", d, 32'h00FFFFFF);
    reg_rd(A_ALERT, d); check("R1 alert", d, 32'h00FFFFFF);

    // R11 start write reloads pointer
    reg_wr(A_START, 32'h0000_0100);
    reg_wr(A_END, 32'h0000_0200);
    reg_rd(A_CUR, d); check("R11 start reload", d, 32'h100);

    // R2/R3/R10 vector walk
    foreach (VEC[i]) begin
      advance(VEC[i].bytes);
      check("R10 irq follows wrap", {31'd0, irq}, {31'd0, VEC[i].wrap});
      reg_rd(A_CUR, d);
      check(VEC[i].wrap ? "R3 wrapped pointer" : "R2 advanced pointer", d, {8'd0, VEC[i].cur});
      reg_rd(A_STAT, d);
      check("R3 wrap flag", d, {29'd0, VEC[i].wrap, 2'b00});
      reg_wr(A_STAT, 32'h4);
    end

    // R4 alert level behaviour (pointer 0x110)
    reg_wr(A_ALERT, 32'h150);
    reg_rd(A_STAT, d); check("R4 below alert", d, 32'h0);
    advance(16'h0040);
    @(posedge clk); #1;
    reg_rd(A_STAT, d); check("R4 alert set", d, 32'h1);
    check("R10 irq on alert", {31'd0, irq}, 32'd1);
    reg_wr(A_STAT, 32'h1);
    reg_rd(A_STAT, d); check("R4 cleared one cycle", d, 32'h0);
    reg_rd(A_STAT, d); check("R4 re-asserts", d, 32'h1);
    reg_wr(A_ALERT, 32'h1F0);
    reg_wr(A_STAT, 32'h1);
    reg_rd(A_STAT, d); check("R4 stays clear", d, 32'h0);
    reg_rd(A_STAT, d); check("R4 stays clear 2", d, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    // R6/R7 frame report (pointer 0x150)
    frame_pulse();
    reg_rd(A_STAT, d);  check("R6 frame flag", d, 32'h2);
    reg_rd(A_FRAME, d); check("R7 report", d, 32'h0900_0150);
    reg_rd(A_FRAME, d); check("R7 read once", d, 32'h0);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, d);  check("R6 clear no pending", d, 32'h0);
    reg_rd(A_STAT, d);  check("R6 stays clear", d, 32'h0);

    frame_pulse();
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, d);  check("R6 cleared one cycle", d, 32'h0);
    reg_rd(A_STAT, d);  check("R6 re-asserts pending", d, 32'h2);
    reg_rd(A_FRAME, d); check("R7 pending report", d, 32'h0900_0150);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, d);  check("R6 clear after read", d, 32'h0);

    // R8 two-entry backlog
    frame_pulse();
    advance(16'h0010);
    frame_pulse();
    reg_rd(A_FRAME, d); check("R8 older first", d, 32'h0900_0150);
    reg_rd(A_FRAME, d); check("R8 newer second", d, 32'h0900_0160);
    reg_rd(A_FRAME, d); check("R8 then empty", d, 32'h0);
    reg_rd(A_STAT, d);  check("R8 no overflow", d, 32'h2);
    reg_wr(A_STAT, 32'h2);

    // R9 overflow on third unread report
    frame_pulse();
    advance(16'h0010);
    frame_pulse();
    advance(16'h0010);
    frame_pulse();
    reg_rd(A_STAT, d);  check("R9 overflow flag", d, 32'h0A);
    reg_rd(A_FRAME, d); check("R9 error report", d, 32'h0E00_0180);
    reg_rd(A_FRAME, d); check("R9 single entry", d, 32'h0);

    // R5 write-1-to-clear and upper bits
    reg_wr(A_STAT, 32'h0000_0008);
    reg_rd(A_STAT, d);  check("R5 selective clear", d, 32'h02);
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_rd(A_STAT, d);  check("R5 all clear upper zero", d, 32'h0);
    check("R10 irq idle", {31'd0, irq}, 32'd0);

    // R11 pointer register is read-only
    reg_wr(A_CUR, 32'h55);
    reg_rd(A_CUR, d);   check("R11 pointer write ignored", d, 32'h180);
    reg_wr(A_START, 32'h120);
    reg_rd(A_CUR, d);   check("R11 start reload again", d, 32'h120);
    reg_rd(3'd7, d);    check("R11 unmapped index", d, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule